// File: doc/BRIEF.md
# Keyed Index/Data Configuration Port

This block gives a host a two-address window into a bank of configuration registers. Offset 0 of the window is an index port and offset 1 is a data port. The index port selects a register, and accesses through the data port then read or write that register. At reset the whole register space is sealed. A host opens a configuration session by writing the opening key byte to the index port on two writes in a row, and writing the closing key byte ends the session.

While a session is open, the host can do four things:

- read a fixed 16-bit device identifier and a revision byte;
- read a fixed 16-bit vendor identifier;
- pick one of several logical devices through a select register;
- reach a small register bank that belongs to the selected device.

Bit 0 of the first banked register of each device is that device's enable, and the block drives it out continuously. Every accepted bank write is also echoed on a one-cycle register port, so that an attached logical device (for example a watchdog) can follow its own settings.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the port is locked, every `ldev_enable` bit is 0, and reading either port returns 0xFF.
- R2: The session opens only after two back-to-back index-port writes of 0x87. A single 0x87 write leaves the port locked.
- R3: Any other index-port write that falls between the two 0x87 bytes restarts key detection. The sequence 0x87, 0x55, 0x87 leaves the port locked.
- R4: An index-port write of 0xAA during a session locks the port again. Afterwards, reads of the data port return 0xFF and reads of the index port return 0xFF.
- R5: While the port is locked, data-port writes change no register and raise no bank write strobe. Data-port reads return 0xFF.
- R6: Register 0x20 holds the device ID high byte and 0x21 the low byte. Register 0x22 holds the revision. Registers 0x23 and 0x24 hold the vendor ID (0x19, 0x34). All five are read-only, and writes to them are discarded.
- R7: Register 0x07 is the logical-device select, and it can be read and written. Registers 0x30 to 0x30+BANK_REGS-1 are held separately for each logical device and read back what was written.
- R8: A logical device whose bit in LDEV_MASK is clear, or whose number is NUM_LDEV or more, reads 0x00 in its banked registers. Writes to it are discarded, and it raises no strobe.
- R9: `ldev_enable[d]` equals bit 0 of register 0x30 in device d's bank, whichever device is currently selected.
- R10: Each accepted bank write raises `dev_wr_valid` for the cycle after the write. In that cycle the port carries the device number, the register number and the data byte.
- R11: During a session, reading the index port returns the last register number written to it. The index resets to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 1 | 0 selects the index port, 1 selects the data port |
| bus_wdata | input | 8 | Write byte |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe; the result appears on `bus_rdata` after the next edge |
| bus_rdata | output | 8 | Registered read byte |
| ldev_enable | output | NUM_LDEV | Enable bit of each logical device |
| dev_wr_valid | output | 1 | Bank write echo strobe |
| dev_wr_ldev | output | 8 | Device number of the echoed write |
| dev_wr_reg | output | 8 | Register number of the echoed write |
| dev_wr_data | output | 8 | Data of the echoed write |

## Verification
The hardest state to reach is a data-port write that lands while the port is locked yet still points at a live banked register. A write made before the first unlock cannot show anything, because the index is still zero. The stimulus therefore fills a bank register during a session and closes the session with 0xAA. It then writes a different byte through the data port, reopens the session, and confirms that the old value survived. Broken key sequences and writes to an unpopulated device are driven the same way: each is followed by a readback through the normal ports.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

    localparam logic [7:0] KEY_OPEN   = 8'h87;
    localparam logic [7:0] KEY_CLOSE  = 8'hAA;
    localparam logic [7:0] REG_LDSEL  = 8'h07;
    localparam logic [7:0] REG_ID_HI  = 8'h20;
    localparam logic [7:0] REG_ID_LO  = 8'h21;
    localparam logic [7:0] REG_REV    = 8'h22;
    localparam logic [7:0] REG_VND_HI = 8'h23;
    localparam logic [7:0] REG_VND_LO = 8'h24;
    localparam logic [7:0] BANK_BASE  = 8'h30;
    localparam logic [7:0] LOCKED_RD  = 8'hFF;

    typedef enum logic [1:0] {
        KS_LOCKED = 2'd0,
        KS_HALF   = 2'd1,
        KS_OPEN   = 2'd2
    } key_state_t;

    typedef struct packed {
        logic       valid;
        logic [7:0] ldev;
        logic [7:0] regno;
        logic [7:0] data;
    } bank_echo_t;

    function automatic logic in_bank(input logic [7:0] idx, input int unsigned nregs);
        return (idx >= BANK_BASE) && ({24'd0, idx} < {24'd0, BANK_BASE} + nregs);
    endfunction

endpackage

// File: rtl/sio_key_detect.sv
module sio_key_detect
    import sio_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output logic       cfg_open
);

    key_state_t state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= KS_LOCKED;
        end else if (idx_wr) begin
            case (state_q)
                KS_LOCKED: state_q <= (wdata == KEY_OPEN) ? KS_HALF : KS_LOCKED;
                KS_HALF:   state_q <= (wdata == KEY_OPEN) ? KS_OPEN : KS_LOCKED;
                KS_OPEN:   state_q <= (wdata == KEY_CLOSE) ? KS_LOCKED : KS_OPEN;
                default:   state_q <= KS_LOCKED;
            endcase
        end
    end

    assign cfg_open = (state_q == KS_OPEN);

endmodule

// File: rtl/sio_ldev_bank.sv
module sio_ldev_bank #(
    parameter int unsigned NUM_LDEV  = 8,
    parameter int unsigned BANK_REGS = 16,
    parameter logic [NUM_LDEV-1:0] LDEV_MASK = '1,
    localparam int unsigned OFF_W = (BANK_REGS > 1) ? $clog2(BANK_REGS) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [7:0]          ldev,
    input  logic [OFF_W-1:0]    off,
    input  logic [7:0]          wdata,
    output logic [7:0]          rdata,
    output logic                wr_accept,
    output logic [NUM_LDEV-1:0] dev_en
);

    logic [7:0]          rd_vals [NUM_LDEV];
    logic [NUM_LDEV-1:0] hit;

    for (genvar d = 0; d < NUM_LDEV; d++) begin : g_dev
        if (LDEV_MASK[d]) begin : g_pop
            logic [7:0] regs_q [BANK_REGS];
            assign hit[d] = wr_en && (ldev == 8'(d));
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int r = 0; r < BANK_REGS; r++) regs_q[r] <= 8'h00;
                end else if (hit[d]) begin
                    regs_q[off] <= wdata;
                end
            end
            assign rd_vals[d] = regs_q[off];
            assign dev_en[d]  = regs_q[0][0];
        end else begin : g_empty
            assign hit[d]     = 1'b0;
            assign rd_vals[d] = 8'h00;
            assign dev_en[d]  = 1'b0;
        end
    end

    always_comb begin
        rdata = 8'h00;
        for (int d = 0; d < NUM_LDEV; d++)
            if (ldev == 8'(d)) rdata = rd_vals[d];
    end

    assign wr_accept = |hit;

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
    import sio_cfg_pkg::*;
#(
    parameter int unsigned NUM_LDEV  = 8,
    parameter int unsigned BANK_REGS = 16,
    parameter logic [NUM_LDEV-1:0] LDEV_MASK = 8'h81,
    parameter logic [15:0] DEV_ID    = 16'h0A51,
    parameter logic [7:0]  DEV_REV   = 8'h03,
    parameter logic [15:0] VENDOR_ID = 16'h1934
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_addr,
    input  logic [7:0]          bus_wdata,
    input  logic                bus_wr,
    input  logic                bus_rd,
    output logic [7:0]          bus_rdata,
    output logic [NUM_LDEV-1:0] ldev_enable,
    output logic                dev_wr_valid,
    output logic [7:0]          dev_wr_ldev,
    output logic [7:0]          dev_wr_reg,
    output logic [7:0]          dev_wr_data
);

    localparam int unsigned OFF_W = (BANK_REGS > 1) ? $clog2(BANK_REGS) : 1;

    logic             cfg_open;
    logic [7:0]       index_q;
    logic [7:0]       ldsel_q;
    logic             idx_wr, dat_wr, bank_sel, bank_wr, bank_acc;
    logic [OFF_W-1:0] bank_off;
    logic [7:0]       bank_rd, reg_rd;
    bank_echo_t       echo_q;

    assign idx_wr   = bus_wr && !bus_addr;
    assign dat_wr   = bus_wr && bus_addr && cfg_open;
    assign bank_sel = in_bank(index_q, BANK_REGS);
    assign bank_off = OFF_W'(index_q - BANK_BASE);
    assign bank_wr  = dat_wr && bank_sel;

    sio_key_detect u_key (
        .clk      (clk),
        .rst      (rst),
        .idx_wr   (idx_wr),
        .wdata    (bus_wdata),
        .cfg_open (cfg_open)
    );

    sio_ldev_bank #(
        .NUM_LDEV  (NUM_LDEV),
        .BANK_REGS (BANK_REGS),
        .LDEV_MASK (LDEV_MASK)
    ) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (bank_wr),
        .ldev      (ldsel_q),
        .off       (bank_off),
        .wdata     (bus_wdata),
        .rdata     (bank_rd),
        .wr_accept (bank_acc),
        .dev_en    (ldev_enable)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            index_q <= 8'h00;
            ldsel_q <= 8'h00;
        end else begin
            if (idx_wr && cfg_open && bus_wdata != KEY_CLOSE) index_q <= bus_wdata;
            if (dat_wr && index_q == REG_LDSEL) ldsel_q <= bus_wdata;
        end
    end

    always_comb begin
        case (index_q)
            REG_LDSEL:  reg_rd = ldsel_q;
            REG_ID_HI:  reg_rd = DEV_ID[15:8];
            REG_ID_LO:  reg_rd = DEV_ID[7:0];
            REG_REV:    reg_rd = DEV_REV;
            REG_VND_HI: reg_rd = VENDOR_ID[15:8];
            REG_VND_LO: reg_rd = VENDOR_ID[7:0];
            default:    reg_rd = bank_sel ? bank_rd : 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= LOCKED_RD;
            echo_q    <= '0;
        end else begin
            if (bus_rd) begin
                if (!cfg_open)     bus_rdata <= LOCKED_RD;
                else if (!bus_addr) bus_rdata <= index_q;
                else               bus_rdata <= reg_rd;
            end
            echo_q.valid <= bank_acc;
            if (bank_acc) begin
                echo_q.ldev  <= ldsel_q;
                echo_q.regno <= index_q;
                echo_q.data  <= bus_wdata;
            end
        end
    end

    assign dev_wr_valid = echo_q.valid;
    assign dev_wr_ldev  = echo_q.ldev;
    assign dev_wr_reg   = echo_q.regno;
    assign dev_wr_data  = echo_q.data;

endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
    parameter int unsigned NUM_LDEV = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                bus_addr,
    input logic [7:0]          bus_wdata,
    input logic                bus_wr,
    input logic                bus_rd,
    input logic [7:0]          bus_rdata,
    input logic                cfg_open,
    input logic [NUM_LDEV-1:0] ldev_enable,
    input logic                dev_wr_valid
);

    // R2
    open_after_key_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_open) |-> $past(bus_wr && !bus_addr && bus_wdata == 8'h87));

    // R4
    close_key_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_open && bus_wr && !bus_addr && bus_wdata == 8'hAA) |=> !cfg_open);

    // R5
    locked_read_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !cfg_open) |=> (bus_rdata == 8'hFF));

    // R5
    echo_needs_session_chk: assert property (@(posedge clk) disable iff (rst)
        dev_wr_valid |-> $past(cfg_open && bus_wr && bus_addr));

    // R9
    enable_moves_with_echo_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(ldev_enable) |-> dev_wr_valid);

endmodule

bind sio_cfg_port sio_cfg_port_chk #(.NUM_LDEV(NUM_LDEV)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_rdata    (bus_rdata),
    .cfg_open     (cfg_open),
    .ldev_enable  (ldev_enable),
    .dev_wr_valid (dev_wr_valid)
);

// File: tb/sio_cfg_port_bench.sv
module sio_cfg_port_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NLD = 8;
    localparam logic [NLD-1:0] MASK = 8'h81;
    localparam logic [15:0] ID  = 16'h0A51;
    localparam logic [7:0]  REV = 8'h03;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           bus_addr = 1'b0;
    logic [7:0]     bus_wdata = 8'h00;
    logic           bus_wr = 1'b0;
    logic           bus_rd = 1'b0;
    logic [7:0]     bus_rdata;
    logic [NLD-1:0] ldev_enable;
    logic           dev_wr_valid;
    logic [7:0]     dev_wr_ldev, dev_wr_reg, dev_wr_data;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sio_cfg_port #(
        .NUM_LDEV (NLD), .BANK_REGS (16), .LDEV_MASK (MASK),
        .DEV_ID (ID), .DEV_REV (REV), .VENDOR_ID (16'h1934)
    ) u_sio_cfg_port (
        .clk (clk), .rst (rst), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
        .bus_wr (bus_wr), .bus_rd (bus_rd), .bus_rdata (bus_rdata),
        .ldev_enable (ldev_enable), .dev_wr_valid (dev_wr_valid),
        .dev_wr_ldev (dev_wr_ldev), .dev_wr_reg (dev_wr_reg), .dev_wr_data (dev_wr_data)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(posedge clk);
        #1 bus_rd = 1'b0;
    endtask

    task automatic reg_wr(input logic [7:0] r, input logic [7:0] d);
        wr(1'b0, r);
        wr(1'b1, d);
    endtask

    task automatic reg_rd(input logic [7:0] r, input logic [7:0] exp, input string tag);
        wr(1'b0, r);
        rd(1'b1, exp, tag);
    endtask

    // monitor: pops the expected read result after each read edge
    always @(posedge clk) begin
        if (bus_rd) begin
            #2;
            if (exp_q.size() == 0) begin
                chk(1, 0, "unexpected read");
            end else begin
                chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog timeout");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        chk(ldev_enable, 0, "R1 enables after reset");
        rd(1'b1, 8'hFF, "R1 data read locked");
        rd(1'b0, 8'hFF, "R1 index read locked");
        // single key then other byte
        wr(1'b0, 8'h87);
        wr(1'b0, 8'h20);
        rd(1'b1, 8'hFF, "R2 single key stays locked");
        // broken key
        wr(1'b0, 8'h87); wr(1'b0, 8'h55); wr(1'b0, 8'h87);
        rd(1'b1, 8'hFF, "R3 broken key stays locked");
        wr(1'b1, 8'h5A);
        chk(dev_wr_valid, 0, "R5 no echo while locked");
        wr(1'b0, 8'h87);
        // second key completes the run started above
        rd(1'b0, 8'h00, "R11 index after open is reset value");
        reg_rd(8'h20, ID[15:8], "R6 id high");
        reg_rd(8'h21, ID[7:0], "R6 id low");
        reg_rd(8'h22, REV, "R6 revision");
        reg_rd(8'h23, 8'h19, "R6 vendor high");
        reg_rd(8'h24, 8'h34, "R6 vendor low");
        wr(1'b1, 8'h00);
        rd(1'b1, 8'h34, "R6 write discarded");
        rd(1'b0, 8'h24, "R11 index readback");
        reg_wr(8'h07, 8'h07);
        rd(1'b1, 8'h07, "R7 select readback");
        reg_wr(8'h30, 8'h01);
        chk(dev_wr_valid, 1, "R10 echo strobe");
        chk({dev_wr_ldev, dev_wr_reg, dev_wr_data}, {8'h07, 8'h30, 8'h01}, "R10 echo fields");
        chk(ldev_enable, 8'h80, "R9 enable dev7");
        reg_wr(8'h31, 8'h3C);
        rd(1'b1, 8'h3C, "R7 bank readback");
        reg_wr(8'h07, 8'h00);
        chk(dev_wr_valid, 0, "R10 no echo for select write");
        reg_rd(8'h30, 8'h00, "R7 dev0 bank separate");
        wr(1'b1, 8'h01);
        chk(ldev_enable, 8'h81, "R9 enable dev0, dev7 kept");
        reg_wr(8'h07, 8'h03);
        reg_wr(8'h30, 8'hFF);
        chk(dev_wr_valid, 0, "R8 no echo for empty device");
        rd(1'b1, 8'h00, "R8 empty device reads zero");
        chk(ldev_enable, 8'h81, "R8 enables unchanged");
        reg_wr(8'h07, 8'h07);
        reg_rd(8'h31, 8'h3C, "R7 dev7 value kept");
        // close, locked write, reopen
        wr(1'b0, 8'hAA);
        rd(1'b1, 8'hFF, "R4 data locked after close");
        rd(1'b0, 8'hFF, "R4 index locked after close");
        wr(1'b1, 8'h77);
        chk(dev_wr_valid, 0, "R5 locked write no echo");
        wr(1'b0, 8'h87); wr(1'b0, 8'h87);
        rd(1'b0, 8'h31, "R11 index kept across close");
        rd(1'b1, 8'h3C, "R5 locked write ignored");
        repeat (4) @(posedge clk);
        chk(exp_q.size(), 0, "R1 all reads answered");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule